// File: doc/BRIEF.md
# VS-level interrupt pending state

This block holds the hypervisor's software-injected interrupt pending bits for a virtual supervisor and builds the pending word that the machine and hypervisor views of the interrupt pending state present. Software reaches the block through a small register port. A select picks one of five views: the hypervisor injection register, the machine pending view, the hypervisor pending view, the guest external interrupt vector, or the hypervisor status word. In the status word only the guest external interrupt number field is held.

Two platform lines can raise the virtual supervisor timer and external pending bits. These are a timer line from a virtual compare unit and an external line from an interrupt controller. A guest external interrupt vector can also raise the external bit, through the entry that the status word's guest number field selects. These sources appear only in the composed pending views. The injection register reads back only what software last wrote to it. The software interrupt bit is a single storage bit, and the injection register and both pending views share it.

Top module: `vs_irq_pend`

## Requirements
- R1: In the injection view (select 0) only bit 2 (software), bit 6 (timer) and bit 10 (external) can be written. Every other bit reads 0.
- R2: The software pending bit (bit 2) is one storage bit. A write of bit 2 through the injection view (0), the machine view (1) or the hypervisor pending view (2) is seen at bit 2 of all three views.
- R3: Bit 10 of the machine and hypervisor pending views, and of `vs_pend`, is the OR of the injected external bit, the selected guest external bit, and `plat_vseip`.
- R4: Bit 6 of the machine and hypervisor pending views, and of `vs_pend`, is the OR of the injected timer bit and `plat_vstip`.
- R5: Bits 6 and 10 of the injection view show only the last values written to the injection view. They never reflect `plat_vstip`, `plat_vseip`, `guest_eip` or the guest number.
- R6: A write to the machine or hypervisor pending view stores only bit 2. Bits 6 and 10 of the written value change no state.
- R7: The guest number is a 6-bit field at bits 17:12 of the status view (select 4), and every other bit of that view reads 0. A guest number of 0, or one above NGUEST, selects no guest bit and contributes 0.
- R8: The guest vector view (select 3) shows `guest_eip` bits 1 to NGUEST. Bit 0 and bits above NGUEST read 0, and writes to this view are ignored. Selects 5 to 7 read 0, and writes to them are ignored.
- R9: A synchronous active-high reset clears the injected bits, the shared software bit and the guest number.
- R10: Reads are combinational from the current state and inputs. A write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_sel | input | 3 | View select: 0 injection, 1 machine pending, 2 hypervisor pending, 3 guest vector, 4 status |
| csr_we | input | 1 | Write enable for the selected view |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data of the selected view |
| plat_vstip | input | 1 | Platform virtual supervisor timer line |
| plat_vseip | input | 1 | Platform virtual supervisor external line |
| guest_eip | input | XLEN | Guest external interrupt vector |
| vs_pend | output | XLEN | Composed pending word |

## Verification
Read data and `vs_pend` depend combinationally on state and inputs. The bench therefore samples them one time unit after it changes `plat_*`, `guest_eip` or the select, with no clock edge in between. A write is due one edge later. The bench drives the write in the low phase, checks before the rising edge that the old value still reads back, and checks after the edge that the new value reads back. The sweeps cover all eight injection patterns against the four platform line combinations, all 64 guest numbers against two guest vectors, and the ignored write paths.

// File: rtl/vs_irq_pend_pkg.sv
package vs_irq_pend_pkg;
  localparam int BIT_SOFT = 2;
  localparam int BIT_TIMER = 6;
  localparam int BIT_EXT = 10;
  localparam int GNUM_LSB = 12;
  localparam int GNUM_W = 6;

  typedef enum logic [2:0] {
    SEL_INJ    = 3'd0,
    SEL_MPEND  = 3'd1,
    SEL_HPEND  = 3'd2,
    SEL_GVEC   = 3'd3,
    SEL_STATUS = 3'd4
  } view_sel_e;
endpackage

// File: rtl/vs_inject_store.sv
module vs_inject_store
  import vs_irq_pend_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [XLEN-1:0]   wdata,
  output logic              inj_ext,
  output logic              inj_timer,
  output logic              soft_bit,
  output logic [GNUM_W-1:0] gnum
);
  view_sel_e vsel;
  assign vsel = view_sel_e'(sel);

  logic wr_inj, wr_pend, wr_stat;
  assign wr_inj  = we && (vsel == SEL_INJ);
  assign wr_pend = we && (vsel == SEL_MPEND || vsel == SEL_HPEND);
  assign wr_stat = we && (vsel == SEL_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      inj_ext   <= 1'b0;
      inj_timer <= 1'b0;
      soft_bit  <= 1'b0;
      gnum      <= '0;
    end else begin
      if (wr_inj) begin
        inj_ext   <= wdata[BIT_EXT];
        inj_timer <= wdata[BIT_TIMER];
      end
      if (wr_inj || wr_pend)
        soft_bit <= wdata[BIT_SOFT];
      if (wr_stat)
        gnum <= wdata[GNUM_LSB +: GNUM_W];
    end
  end

  AST_INJ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_inj |=> $stable({inj_ext, inj_timer})); // R6

  AST_SOFT_SHARED: assert property (@(posedge clk) disable iff (rst)
    wr_pend |=> soft_bit == $past(wdata[BIT_SOFT])); // R2

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !inj_ext && !inj_timer && !soft_bit && gnum == '0); // R9
endmodule

// File: rtl/vs_guest_pick.sv
module vs_guest_pick
  import vs_irq_pend_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NGUEST = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   guest_eip,
  input  logic [GNUM_W-1:0] gnum,
  output logic              picked,
  output logic [XLEN-1:0]   gvec_view
);
  genvar g;
  generate
    for (g = 0; g < XLEN; g++) begin : g_view
      if (g >= 1 && g <= NGUEST) begin : g_live
        assign gvec_view[g] = guest_eip[g];
      end else begin : g_zero
        assign gvec_view[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    picked = 1'b0;
    for (int i = 1; i <= NGUEST; i++) begin
      if (int'(gnum) == i) picked = guest_eip[i];
    end
  end

  AST_GNUM_NONE: assert property (@(posedge clk) disable iff (rst)
    (gnum == '0 || int'(gnum) > NGUEST) |-> !picked); // R7

  AST_GVEC_BIT0: assert property (@(posedge clk) disable iff (rst)
    !gvec_view[0]); // R8
endmodule

// File: rtl/vs_pend_compose.sv
module vs_pend_compose
  import vs_irq_pend_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            inj_ext,
  input  logic            inj_timer,
  input  logic            soft_bit,
  input  logic            plat_ext,
  input  logic            plat_timer,
  input  logic            guest_bit,
  output logic [XLEN-1:0] pend_word
);
  always_comb begin
    pend_word = '0;
    pend_word[BIT_SOFT]  = soft_bit;
    pend_word[BIT_TIMER] = inj_timer | plat_timer;
    pend_word[BIT_EXT]   = inj_ext | guest_bit | plat_ext;
  end
endmodule

// File: rtl/vs_irq_pend.sv
module vs_irq_pend
  import vs_irq_pend_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NGUEST = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      csr_sel,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            plat_vstip,
  input  logic            plat_vseip,
  input  logic [XLEN-1:0] guest_eip,
  output logic [XLEN-1:0] vs_pend
);
  localparam logic [XLEN-1:0] INJ_MASK =
    (XLEN'(1) << BIT_SOFT) | (XLEN'(1) << BIT_TIMER) | (XLEN'(1) << BIT_EXT);

  logic              inj_ext, inj_timer, soft_bit, picked;
  logic [GNUM_W-1:0] gnum;
  logic [XLEN-1:0]   gvec_view, pend_word, inj_view;

  vs_inject_store #(.XLEN(XLEN)) u_store (
    .clk(clk), .rst(rst), .we(csr_we), .sel(csr_sel), .wdata(csr_wdata),
    .inj_ext(inj_ext), .inj_timer(inj_timer), .soft_bit(soft_bit), .gnum(gnum)
  );

  vs_guest_pick #(.XLEN(XLEN), .NGUEST(NGUEST)) u_pick (
    .clk(clk), .rst(rst), .guest_eip(guest_eip), .gnum(gnum),
    .picked(picked), .gvec_view(gvec_view)
  );

  vs_pend_compose #(.XLEN(XLEN)) u_comp (
    .inj_ext(inj_ext), .inj_timer(inj_timer), .soft_bit(soft_bit),
    .plat_ext(plat_vseip), .plat_timer(plat_vstip), .guest_bit(picked),
    .pend_word(pend_word)
  );

  always_comb begin
    inj_view = '0;
    inj_view[BIT_SOFT]  = soft_bit;
    inj_view[BIT_TIMER] = inj_timer;
    inj_view[BIT_EXT]   = inj_ext;
  end

  always_comb begin
    case (view_sel_e'(csr_sel))
      SEL_INJ:               csr_rdata = inj_view;
      SEL_MPEND, SEL_HPEND:  csr_rdata = pend_word;
      SEL_GVEC:              csr_rdata = gvec_view;
      SEL_STATUS:            csr_rdata = XLEN'(gnum) << GNUM_LSB;
      default:               csr_rdata = '0;
    endcase
  end

  assign vs_pend = pend_word;

  AST_INJ_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (csr_sel == 3'd0) |-> (csr_rdata & ~INJ_MASK) == '0); // R1

  AST_EXT_PLAT: assert property (@(posedge clk) disable iff (rst)
    plat_vseip |-> vs_pend[BIT_EXT]); // R3

  AST_TIMER_PLAT: assert property (@(posedge clk) disable iff (rst)
    plat_vstip |-> vs_pend[BIT_TIMER]); // R4

  AST_INJ_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    (csr_sel == 3'd0 && $past(csr_sel) == 3'd0 && !$past(csr_we))
      |-> $stable(csr_rdata)); // R5
endmodule

// File: tb/vs_irq_pend_tb.sv
`timescale 1ns/1ps
module vs_irq_pend_tb;
  localparam int XLEN = 64;
  localparam int NG = 7;

  logic clk = 1'b0;
  logic rst;
  logic [2:0] csr_sel;
  logic csr_we;
  logic [XLEN-1:0] csr_wdata, csr_rdata, guest_eip, vs_pend;
  logic plat_vstip, plat_vseip;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vs_irq_pend #(.XLEN(XLEN), .NGUEST(NG)) u_dut (
    .clk(clk), .rst(rst), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .plat_vstip(plat_vstip),
    .plat_vseip(plat_vseip), .guest_eip(guest_eip), .vs_pend(vs_pend)
  );

  // reference state
  logic m_soft, m_tim, m_ext;
  logic [5:0] m_gnum;

  function automatic logic [XLEN-1:0] exp_pend();
    logic [XLEN-1:0] w = '0;
    logic gb = (m_gnum != 0 && m_gnum <= NG) ? guest_eip[m_gnum] : 1'b0;
    w[2]  = m_soft;
    w[6]  = m_tim | plat_vstip;
    w[10] = m_ext | plat_vseip | gb;
    return w;
  endfunction

  function automatic logic [XLEN-1:0] exp_inj();
    logic [XLEN-1:0] w = '0;
    w[2] = m_soft; w[6] = m_tim; w[10] = m_ext;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, input string tag, input logic [XLEN-1:0] exp);
    csr_sel = s;
    #1;
    chk(tag, csr_rdata, exp);
  endtask

  // drive in low phase, write lands at the next rising edge
  task automatic wr(input logic [2:0] s, input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_sel = s; csr_wdata = d; csr_we = 1'b1;
    @(posedge clk);
    #1;
    csr_we = 1'b0;
    if (s == 3'd0) begin m_tim = d[6]; m_ext = d[10]; end
    if (s <= 3'd2) m_soft = d[2];
    if (s == 3'd4) m_gnum = d[17:12];
  endtask

  initial begin
    #150000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; csr_sel = 3'd0; csr_we = 1'b0; csr_wdata = '0;
    plat_vstip = 1'b0; plat_vseip = 1'b0; guest_eip = '0;
    m_soft = 0; m_tim = 0; m_ext = 0; m_gnum = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    rd(3'd0, "R9 reset inj", '0);
    rd(3'd1, "R9 reset mpend", '0);
    rd(3'd4, "R9 reset status", '0);

    // R1: all ones write keeps only bits 2,6,10
    wr(3'd0, '1);
    rd(3'd0, "R1 inj mask", 64'h444);

    // R3 R4 R5: injection patterns x platform lines
    for (int p = 0; p < 8; p++) begin
      logic [XLEN-1:0] d = '0;
      d[2] = p[0]; d[6] = p[1]; d[10] = p[2];
      wr(3'd0, d);
      for (int q = 0; q < 4; q++) begin
        plat_vstip = q[0]; plat_vseip = q[1];
        guest_eip = '1;
        rd(3'd0, "R5 inj isolated", exp_inj());
        rd(3'd1, "R3 R4 mpend", exp_pend());
        rd(3'd2, "R3 R4 hpend", exp_pend());
        chk("R4 vs_pend", vs_pend, exp_pend());
      end
    end
    plat_vstip = 0; plat_vseip = 0;

    // R2: shared soft bit through each view
    for (int s = 0; s < 3; s++) begin
      wr(s[2:0], 64'h4);
      rd(3'd0, "R2 soft inj", exp_inj());
      rd(3'd1, "R2 soft mpend", exp_pend());
      wr(s[2:0], 64'h0);
      rd(3'd2, "R2 soft clear hpend", exp_pend());
    end

    // R6: pending-view writes do not store timer/external
    wr(3'd0, 64'h0);
    wr(3'd1, 64'h444);
    rd(3'd0, "R6 mpend write", 64'h4);
    wr(3'd2, 64'h440);
    rd(3'd0, "R6 hpend write", 64'h0);

    // R7: guest number sweep
    for (int pat = 0; pat < 2; pat++) begin
      guest_eip = pat ? 64'h5555_5555_5555_5555 : 64'hAAAA_AAAA_AAAA_AAAA;
      for (int v = 0; v < 64; v++) begin
        wr(3'd4, (64'(v) << 12) | 64'hFFFF_FFFF_FFFC_0FFF);
        rd(3'd4, "R7 status", 64'(v) << 12);
        rd(3'd1, "R7 guest pick", exp_pend());
        rd(3'd0, "R5 inj gnum", exp_inj());
      end
    end

    // R8: guest vector view and ignored writes
    guest_eip = '1;
    rd(3'd3, "R8 gvec", 64'hFE);
    wr(3'd3, 64'h444);
    rd(3'd0, "R8 gvec write ignored", exp_inj());
    rd(3'd3, "R8 gvec after write", 64'hFE);
    for (int s = 5; s < 8; s++) begin
      wr(s[2:0], '1);
      rd(s[2:0], "R8 unused sel", '0);
      rd(3'd0, "R8 unused write ignored", exp_inj());
    end

    // R10: write lands at the edge, not before
    @(negedge clk);
    csr_sel = 3'd0; csr_wdata = 64'h400; csr_we = 1'b1;
    #1 chk("R10 before edge", csr_rdata, exp_inj());
    @(posedge clk); #1;
    csr_we = 1'b0; m_ext = 1; m_tim = 0; m_soft = 0;
    chk("R10 after edge", csr_rdata, 64'h400);

    // R9: reset clears again
    wr(3'd4, 64'h3000);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    m_soft = 0; m_tim = 0; m_ext = 0; m_gnum = 0;
    rd(3'd0, "R9 reset2 inj", '0);
    rd(3'd4, "R9 reset2 status", '0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule